// File: doc/BRIEF.md
# Six-Position Multiplexed Seven-Segment Scanner

This block drives six seven-segment positions that share one segment bus. It enables one position at a time. Five positions show the nibbles of a packed 20-bit value, most significant nibble first. A decimal point is placed at the position given by an index. The sixth position shows a one-segment glyph that marks the unit of the value, chosen by a 2-bit mode code.

The scan moves to the next position once per tick. The tick period is a parameter counted in clock cycles. Each position change is preceded by exactly one clock cycle in which every position is dark. This keeps the segment data of one position from showing on its neighbour.

The value, the decimal-point index and the mode are captured when the scan enters position 0. A whole frame therefore shows one consistent reading, even if the producer updates its inputs mid-frame.

Top module: `seg_scan_display`

## Requirements
- R1: While reset is applied, and after release until the first tick, `blank_o` is 1, `seg_o` is 0 and `sel_o` is 5.
- R2: Shown positions follow the order 0,1,2,3,4,5 and wrap back to 0 after 5.
- R3: Successive starts of a shown (unblanked) position lie exactly TICK_CYCLES clock cycles apart.
- R4: Every position change is preceded by exactly one cycle with `blank_o`=1. During that cycle `seg_o` is 0, and `sel_o` only changes as blanking ends.
- R5: Position p (0 to 4) shows the nibble `value_i[(4-p)*4+3 : (4-p)*4]`, so position 0 shows the most significant nibble.
- R6: The segment bus uses bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g. Digits 0..F encode as 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex, bits 6..0).
- R7: Bit 7 (the dot) is lit at position p (0 to 4) exactly when `dp_idx_i` equals 4-p. Index values 5 to 7 light no dot.
- R8: Position 5 shows 8'h01 (segment a) for mode 0, 8'h40 (segment g) for mode 1, 8'h08 (segment d) for mode 2, and 8'h00 for mode 3. It never lights the dot.
- R9: The inputs are captured on the transition into position 0. Input changes during a frame do not alter positions 1 to 5 of that frame.
- R10: While a position is shown, `seg_o` and `sel_o` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| value_i | input | 20 | Five packed nibbles, position 0 in bits 19:16 |
| dp_idx_i | input | 3 | Decimal-point index (lit at position 4-index) |
| mode_i | input | 2 | Unit glyph select for position 5 |
| seg_o | output | 8 | Segment bus, bit0=a .. bit6=g, bit7=dot |
| sel_o | output | 3 | Index of the enabled position |
| blank_o | output | 1 | 1 = all positions dark |

## Verification
A wrong position counter shows up at the very next unblanking as a skipped, repeated or out-of-range `sel_o`. A wrong tick counter shifts the spacing of unblank events within one tick period. A snapshot register that loads at the wrong time shows up within the same frame: positions after an input change display the new nibbles instead of the captured ones. Encoding or index faults show as a wrong `seg_o` at the first position that uses the affected nibble, dot or mode.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  // hexadecimal nibble to segment pattern, bit0=a .. bit6=g
  function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

  // unit glyph: one segment per mode code, code 3 dark
  function automatic logic [7:0] unit_glyph(input logic [1:0] mode);
    logic [7:0] g;
    case (mode)
      2'd0: g = 8'h01;
      2'd1: g = 8'h40;
      2'd2: g = 8'h08;
      default: g = 8'h00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_scan_rst_sync.sv
module seg_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seg_scan_tick.sv
module seg_scan_tick #(
  parameter int TICK_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNTW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            wrap;

  assign wrap = (cnt_q == CNTW'(TICK_CYCLES - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/seg_scan_encode.sv
module seg_scan_encode
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 5,
  localparam int SELW = $clog2(NUM_DIGITS + 1),
  localparam int VALW = NUM_DIGITS * 4
) (
  input  logic [SELW-1:0] pos_i,
  input  logic [VALW-1:0] val_i,
  input  logic [SELW-1:0] dp_i,
  input  logic [1:0]      mode_i,
  output logic [7:0]      seg_o
);
  logic [VALW-1:0] shifted;
  logic [SELW-1:0] rev_idx;
  int              shamt;

  always_comb begin
    rev_idx = SELW'(NUM_DIGITS - 1) - pos_i;
    shamt   = 4 * int'(rev_idx);
    shifted = val_i >> shamt;
    if (int'(pos_i) >= NUM_DIGITS) begin
      seg_o = unit_glyph(mode_i);
    end else begin
      seg_o = {(dp_i == rev_idx), hex_to_seg(shifted[3:0])};
    end
  end
endmodule

// File: rtl/seg_scan_seq.sv
module seg_scan_seq #(
  parameter int NUM_DIGITS = 5,
  localparam int SELW = $clog2(NUM_DIGITS + 1),
  localparam int VALW = NUM_DIGITS * 4,
  localparam int LAST = NUM_DIGITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [VALW-1:0] value_i,
  input  logic [SELW-1:0] dp_i,
  input  logic [1:0]      mode_i,
  output logic [7:0]      seg_o,
  output logic [SELW-1:0] sel_o,
  output logic            blank_o
);
  logic [SELW-1:0] pos_q, pos_d, pos_adv;
  logic            pend_q, pend_d;
  logic            blank_q, blank_d;
  logic [7:0]      seg_q, seg_d, seg_new;
  logic [VALW-1:0] val_q, val_d, val_src;
  logic [SELW-1:0] dp_q, dp_d, dp_src;
  logic [1:0]      mode_q, mode_d, mode_src;
  logic            load;

  assign pos_adv  = (pos_q == SELW'(LAST)) ? '0 : pos_q + 1'b1;
  assign load     = pend_q && (pos_adv == '0);
  assign val_src  = load ? value_i : val_q;
  assign dp_src   = load ? dp_i    : dp_q;
  assign mode_src = load ? mode_i  : mode_q;

  seg_scan_encode #(.NUM_DIGITS(NUM_DIGITS)) u_enc (
    .pos_i (pos_adv),
    .val_i (val_src),
    .dp_i  (dp_src),
    .mode_i(mode_src),
    .seg_o (seg_new)
  );

  always_comb begin
    pos_d   = pos_q;
    pend_d  = pend_q;
    blank_d = blank_q;
    seg_d   = seg_q;
    val_d   = val_src;
    dp_d    = dp_src;
    mode_d  = mode_src;
    if (tick_i) begin
      blank_d = 1'b1;
      seg_d   = '0;
      pend_d  = 1'b1;
    end else if (pend_q) begin
      pos_d   = pos_adv;
      blank_d = 1'b0;
      seg_d   = seg_new;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= SELW'(LAST);
      pend_q  <= 1'b0;
      blank_q <= 1'b1;
      seg_q   <= '0;
      val_q   <= '0;
      dp_q    <= '0;
      mode_q  <= '0;
    end else begin
      pos_q   <= pos_d;
      pend_q  <= pend_d;
      blank_q <= blank_d;
      seg_q   <= seg_d;
      val_q   <= val_d;
      dp_q    <= dp_d;
      mode_q  <= mode_d;
    end
  end

  assign seg_o   = seg_q;
  assign sel_o   = pos_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display #(
  parameter int TICK_CYCLES = 100000,
  parameter int NUM_DIGITS  = 5,
  localparam int SELW = $clog2(NUM_DIGITS + 1),
  localparam int VALW = NUM_DIGITS * 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VALW-1:0] value_i,
  input  logic [SELW-1:0] dp_idx_i,
  input  logic [1:0]      mode_i,
  output logic [7:0]      seg_o,
  output logic [SELW-1:0] sel_o,
  output logic            blank_o
);
  logic rst_int_n;
  logic tick;

  seg_scan_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  seg_scan_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick_o(tick)
  );

  seg_scan_seq #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick),
    .value_i(value_i),
    .dp_i   (dp_idx_i),
    .mode_i (mode_i),
    .seg_o  (seg_o),
    .sel_o  (sel_o),
    .blank_o(blank_o)
  );
endmodule

// File: rtl/seg_scan_display_chk.sv
module seg_scan_display_chk #(
  parameter int NUM_DIGITS = 5,
  localparam int SELW = $clog2(NUM_DIGITS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      seg_o,
  input logic [SELW-1:0] sel_o,
  input logic            blank_o
);
  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_o) <= NUM_DIGITS);

  // R2
  sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_o) |->
      ((int'($past(sel_o)) == NUM_DIGITS) ? (sel_o == '0) : (sel_o == $past(sel_o) + 1'b1)));

  // R4
  change_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_o) |-> ($past(blank_o) && !blank_o));

  // R4
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (seg_o == 8'h00));

  // R4
  blank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |=> !blank_o);

  // R8
  glyph_one_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_o && int'(sel_o) == NUM_DIGITS) |-> ($countones(seg_o) <= 1 && !seg_o[7]));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_o && $past(!blank_o)) |-> ($stable(seg_o) && $stable(sel_o)));
endmodule

bind seg_scan_display seg_scan_display_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .seg_o  (seg_o),
  .sel_o  (sel_o),
  .blank_o(blank_o)
);

// File: tb/seg_scan_display_tb.sv
module seg_scan_display_tb;
  localparam int T = 6;

  logic        clk;
  logic        rst_n;
  logic [19:0] value_i;
  logic [2:0]  dp_idx_i;
  logic [1:0]  mode_i;
  logic [7:0]  seg_o;
  logic [2:0]  sel_o;
  logic        blank_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  seg_scan_display #(.TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .value_i(value_i), .dp_idx_i(dp_idx_i),
    .mode_i(mode_i), .seg_o(seg_o), .sel_o(sel_o), .blank_o(blank_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_hex(input logic [3:0] n);
    logic [6:0] t [16];
    t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic logic [7:0] ref_seg(input int p, input logic [19:0] v,
                                         input logic [2:0] dp, input logic [1:0] m);
    if (p == 5) begin
      case (m)
        2'd0: return 8'h01;
        2'd1: return 8'h40;
        2'd2: return 8'h08;
        default: return 8'h00;
      endcase
    end
    return {(int'(dp) == 4 - p), ref_hex(4'((v >> ((4 - p) * 4)) & 20'hF))};
  endfunction

  // timing monitor: R3, R4, R10
  int   cyc = 0;
  int   last_start = -1;
  int   blank_run = 0;
  bit   prev_blank = 1;
  logic [7:0] prev_seg;
  logic [2:0] prev_sel;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (blank_o) begin
        blank_run++;
        check(seg_o == 8'h00, "R4 dark while blanked", seg_o, 0);
      end else if (prev_blank) begin
        if (last_start >= 0) begin
          check(cyc - last_start == T, "R3 position period", cyc - last_start, T);
          check(blank_run == 1, "R4 single blank cycle", blank_run, 1);
          check(sel_o == ((prev_sel == 3'd5) ? 3'd0 : prev_sel + 3'd1), "R2 scan order",
                sel_o, (prev_sel == 3'd5) ? 0 : prev_sel + 1);
        end
        last_start = cyc;
        blank_run = 0;
      end else begin
        check(seg_o == prev_seg && sel_o == prev_sel, "R10 hold while shown",
              {sel_o, seg_o}, {prev_sel, prev_seg});
      end
      prev_blank = blank_o;
      prev_seg = seg_o;
      prev_sel = sel_o;
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (!(!blank_o && int'(sel_o) == p));
  endtask

  // one frame: inputs already set before position 0; optionally disturb after position 2
  task automatic run_frame(input logic [19:0] v, input logic [2:0] dp, input logic [1:0] m,
                           input bit disturb);
    for (int p = 0; p < 6; p++) begin
      wait_pos(p);
      if (p == 5)
        check(seg_o == ref_seg(p, v, dp, m), "R8 unit glyph", seg_o, ref_seg(p, v, dp, m));
      else begin
        check(seg_o[6:0] == ref_seg(p, v, dp, m)[6:0], "R5 R6 digit nibble/code",
              seg_o, ref_seg(p, v, dp, m));
        check(seg_o[7] == ref_seg(p, v, dp, m)[7], "R7 dot placement",
              seg_o, ref_seg(p, v, dp, m));
      end
      if (disturb && p == 2) begin
        value_i = ~v;
        dp_idx_i = dp + 3'd1;
        mode_i = m + 2'd1;
      end
    end
  endtask

  initial begin
    rst_n = 0;
    value_i = 20'h12345;
    dp_idx_i = 3'd0;
    mode_i = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(blank_o == 1'b1, "R1 blank in reset", blank_o, 1);
    check(seg_o == 8'h00, "R1 seg in reset", seg_o, 0);
    check(sel_o == 3'd5, "R1 sel in reset", sel_o, 5);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(blank_o == 1'b1 && seg_o == 8'h00 && sel_o == 3'd5, "R1 dark before first tick",
          {blank_o, sel_o, seg_o}, {1'b1, 3'd5, 8'h00});
    // first frame with initial inputs
    run_frame(20'h12345, 3'd0, 2'd0, 1'b0);
    // sweep: every nibble value at every position, every dp index, every mode
    for (int k = 0; k < 16; k++) begin
      logic [19:0] v;
      for (int p = 0; p < 5; p++) v[(4 - p) * 4 +: 4] = 4'((k + p * 3) % 16);
      value_i = v;
      dp_idx_i = 3'(k % 8);
      mode_i = 2'(k % 4);
      run_frame(v, 3'(k % 8), 2'(k % 4), 1'b0);
    end
    // R9 inputs changed mid-frame do not affect the frame
    for (int k = 0; k < 4; k++) begin
      logic [19:0] v;
      v = 20'hA5C3E ^ 20'(k * 20'h11111);
      value_i = v;
      dp_idx_i = 3'(k + 1);
      mode_i = 2'(k);
      run_frame(v, 3'(k + 1), 2'(k), 1'b1);
      // frame after: disturbed inputs still present, now captured (R9)
      run_frame(~v, 3'(k + 2), 2'(k + 1), 1'b0);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 20000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule